// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is an up-counter built from identical 4-bit slices. All state bits update together on the rising clock edge. Each slice has a synchronous clear, a synchronous parallel preset and two count enables. Both enables must be high for the slice to advance. Only one of them, the chain enable, also gates the slice's carry output. The top chains the slices: one shared count enable drives every slice. Each slice's chain enable comes from the carry of the slice below it. The whole chain therefore behaves as one wide synchronous counter, with no gating outside the slices.

Clear has the highest priority, preset comes next, then counting, then holding. A user can shorten the count cycle by decoding a chosen count value and driving the active-low clear from that decode. The counter then returns to zero on the edge after the decoded value first appears. The top-level carry rises only while every bit is one and the chain enable is high. This lets a further chain hang off it.

Top module: `bcnt_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count` becomes 0 on that edge, whatever `load_n`, `cnt_en` and `chain_en` are.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes `load_val` on that edge, whatever the enables are.
- R3: When `clr_n` and `load_n` are both 1 and `cnt_en` and `chain_en` are both 1 at a rising edge, `count` increases by exactly one. A carry passes across slice boundaries in the same edge (for example, 0x0FF becomes 0x100).
- R4: When `clr_n` and `load_n` are 1 and either `cnt_en` or `chain_en` is 0 at a rising edge, `count` keeps its value.
- R5: An enabled count from the all-ones value gives all zeros.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `count` is all ones. It is combinational, and `cnt_en` does not affect it.
- R7: Only the levels present at the rising edge decide the operation. Toggling `cnt_en` between edges, when its level at the edge is unchanged, has no effect on `count`.
- R8: Driving `clr_n` from a decode of `count == K` gives a repeating cycle 0, 1, …, K, 0.
- R9: When `rst` is 1 at a rising edge, `count` becomes 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Synchronous clear, active low, top priority |
| load_n | input | 1 | Synchronous preset from `load_val`, active low |
| cnt_en | input | 1 | Count enable shared by all slices; does not gate the carry |
| chain_en | input | 1 | Chain enable of the lowest slice; also gates the carries |
| load_val | input | SLICE_W*STAGES | Preset value |
| count | output | SLICE_W*STAGES | Current count |
| carry_out | output | 1 | High while `count` is all ones and `chain_en` is high |

## Verification
The assertions assume that every control input is a clean 0 or 1 at each rising edge. They also assume that `rst` is held high at the first edge, so that `$past` values refer to defined state. The bench starts with reset high. It changes inputs only one nanosecond after an edge, never at an edge, and it never leaves a control input unknown. When it applies the decoded clear, it derives `clr_n` from the count it sampled after the previous edge. The decode is therefore stable well before the next edge.

// File: rtl/bcnt_pkg.sv
`timescale 1ns/1ps
package bcnt_pkg;

    // Operation selected for a slice at the next rising edge, by priority.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } slice_mode_e;

    // Control levels seen by one slice.
    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic enp;
        logic ent;
    } slice_ctl_t;

    // Priority: reset/clear, then preset, then count, then hold.
    function automatic slice_mode_e pick_mode(input logic rst, input slice_ctl_t c);
        slice_mode_e m;
        if (rst || !c.clr_n)
            m = MODE_CLEAR;
        else if (!c.load_n)
            m = MODE_LOAD;
        else if (c.enp && c.ent)
            m = MODE_COUNT;
        else
            m = MODE_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/bcnt_mode_dec.sv
`timescale 1ns/1ps
module bcnt_mode_dec
    import bcnt_pkg::*;
(
    input  logic        rst,
    input  slice_ctl_t  ctl,
    output slice_mode_e mode
);

    always_comb begin
        mode = pick_mode(rst, ctl);
    end

endmodule

// File: rtl/bcnt_tc_detect.sv
`timescale 1ns/1ps
module bcnt_tc_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         ent,
    output logic         tc,
    output logic         rco
);

    always_comb begin
        tc  = &q;
        rco = ent & tc;
    end

endmodule

// File: rtl/bcnt_slice.sv
`timescale 1ns/1ps
module bcnt_slice
    import bcnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         enp,
    input  logic         ent,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rco
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    slice_ctl_t  ctl;
    slice_mode_e mode;
    logic        tc;
    logic [W-1:0] q_r;

    always_comb begin
        ctl.clr_n  = clr_n;
        ctl.load_n = load_n;
        ctl.enp    = enp;
        ctl.ent    = ent;
    end

    bcnt_mode_dec u_dec (
        .rst  (rst),
        .ctl  (ctl),
        .mode (mode)
    );

    bcnt_tc_detect #(.W(W)) u_tc (
        .q   (q_r),
        .ent (ent),
        .tc  (tc),
        .rco (rco)
    );

    always_ff @(posedge clk) begin
        case (mode)
            MODE_CLEAR: q_r <= ZERO;
            MODE_LOAD:  q_r <= d;
            MODE_COUNT: q_r <= q_r + ONE;
            default:    q_r <= q_r;
        endcase
    end

    assign q = q_r;

    AST_SLICE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> q_r == ZERO);                                          // R1
    AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !load_n) |=> q_r == $past(d));                          // R2
    AST_SLICE_STEP: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && enp && ent) |=> q_r == W'($past(q_r) + ONE)); // R3
    AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && !(enp && ent)) |=> $stable(q_r));             // R4
    AST_SLICE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && enp && ent && tc) |=> q_r == ZERO);           // R5

endmodule

// File: rtl/bcnt_chain.sv
`timescale 1ns/1ps
module bcnt_chain #(
    parameter int SLICE_W = 4,
    parameter int STAGES  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        cnt_en,
    input  logic                        chain_en,
    input  logic [SLICE_W*STAGES-1:0]   load_val,
    output logic [SLICE_W*STAGES-1:0]   count,
    output logic                        carry_out
);

    localparam int W = SLICE_W * STAGES;
    localparam logic [W-1:0] ONE = W'(1);

    // link[i] is the chain enable of slice i; link[STAGES] is the top carry.
    logic [STAGES:0] link;

    assign link[0] = chain_en;

    for (genvar i = 0; i < STAGES; i++) begin : g_slice
        bcnt_slice #(.W(SLICE_W)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .clr_n  (clr_n),
            .load_n (load_n),
            .enp    (cnt_en),
            .ent    (link[i]),
            .d      (load_val[i*SLICE_W +: SLICE_W]),
            .q      (count[i*SLICE_W +: SLICE_W]),
            .rco    (link[i+1])
        );
    end

    assign carry_out = link[STAGES];

    AST_CARRY_IMPLIES_FULL: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (chain_en && (&count)));                            // R6
    AST_FULL_IMPLIES_CARRY: assert property (@(posedge clk) disable iff (rst)
        (chain_en && (&count)) |-> carry_out);                            // R6
    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && cnt_en && chain_en) |=> count == W'($past(count) + ONE)); // R3
    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && !(cnt_en && chain_en)) |=> $stable(count));   // R4

endmodule

// File: tb/bcnt_chain_tb.sv
`timescale 1ns/1ps
module bcnt_chain_tb;

    localparam int SW = 4;
    localparam int ST = 3;
    localparam int W  = SW * ST;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_n = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         carry_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bcnt_chain #(.SLICE_W(SW), .STAGES(ST)) u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .cnt_en(cnt_en), .chain_en(chain_en), .load_val(load_val),
        .count(count), .carry_out(carry_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_carry(input string tag, input logic exp);
        chk(tag, W'(carry_out), W'(exp));
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step();
        chk("R9 reset zero", count, '0);
        rst = 1'b0;
    endtask

    task automatic t_load_clear();
        cnt_en = 1'b0; chain_en = 1'b0;
        load_val = 12'h3E7; load_n = 1'b0; step();
        chk("R2 load with enables low", count, 12'h3E7);
        cnt_en = 1'b1; chain_en = 1'b1; load_val = 12'hA5C; step();
        chk("R2 load with enables high", count, 12'hA5C);
        clr_n = 1'b0; load_val = 12'h111; step();
        chk("R1 clear over load and enables", count, '0);
        clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    endtask

    task automatic t_sequence();
        logic [W-1:0] exp_v;
        clr_n = 1'b0; step(); clr_n = 1'b1;
        chk("R1 clear", count, '0);
        load_val = 12'hFFC; load_n = 1'b0; step(); load_n = 1'b1;
        chk("R2 preset", count, 12'hFFC);
        cnt_en = 1'b1; chain_en = 1'b1;
        exp_v = 12'hFFC;
        for (int i = 0; i < 6; i++) begin
            step();
            exp_v = exp_v + 1'b1;
            chk("R3 R5 count step", count, exp_v);
            chk_carry("R6 carry during sequence", exp_v == ALL1);
        end
        cnt_en = 1'b0; step(); step();
        chk("R4 hold when cnt_en low", count, 12'h002);
    endtask

    task automatic t_carry_gating();
        load_val = ALL1; load_n = 1'b0; step(); load_n = 1'b1;
        cnt_en = 1'b1; chain_en = 1'b0; #1;
        chk_carry("R6 carry low while chain_en low", 1'b0);
        step();
        chk("R4 hold when chain_en low", count, ALL1);
        cnt_en = 1'b0; chain_en = 1'b1; #1;
        chk_carry("R6 carry ignores cnt_en", 1'b1);
        step();
        chk("R4 hold when cnt_en low at all ones", count, ALL1);
        cnt_en = 1'b1; step();
        chk("R5 wrap from all ones", count, '0);
        chk_carry("R6 carry drops after wrap", 1'b0);
    endtask

    task automatic t_cascade();
        cnt_en = 1'b1; chain_en = 1'b1;
        load_val = 12'h0FF; load_n = 1'b0; step(); load_n = 1'b1;
        step();
        chk("R3 carry into third slice", count, 12'h100);
        load_val = 12'h7FF; load_n = 1'b0; step(); load_n = 1'b1;
        step();
        chk("R3 carry across all slices", count, 12'h800);
        load_val = 12'h00F; load_n = 1'b0; step(); load_n = 1'b1;
        step();
        chk("R3 carry into second slice", count, 12'h010);
    endtask

    task automatic t_between_edges();
        cnt_en = 1'b1; chain_en = 1'b1;
        load_val = 12'h040; load_n = 1'b0; step(); load_n = 1'b1;
        cnt_en = 1'b0; #1; cnt_en = 1'b1;
        step();
        chk("R7 glitch low between edges ignored", count, 12'h041);
        cnt_en = 1'b0; #1; cnt_en = 1'b1; #1; cnt_en = 1'b0;
        step();
        chk("R7 glitch high between edges ignored", count, 12'h041);
    endtask

    task automatic t_truncate();
        logic [W-1:0] exp_v;
        clr_n = 1'b0; step(); clr_n = 1'b1;
        cnt_en = 1'b1; chain_en = 1'b1;
        exp_v = '0;
        for (int i = 0; i < 14; i++) begin
            clr_n = (count != 12'h005);
            step();
            exp_v = (exp_v == 12'h005) ? '0 : exp_v + 1'b1;
            chk("R8 decoded clear cycle", count, exp_v);
        end
        clr_n = 1'b1; cnt_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_load_clear();
        t_sequence();
        t_carry_gating();
        t_cascade();
        t_between_edges();
        t_truncate();
        rst = 1'b1; load_val = 12'h5A5; step();
        chk("R9 reset zero later", count, '0);
        finish_run();
    end

endmodule